// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K bytes. The host hands over one request at a time through a valid/ready handshake: an 18-bit address, a write flag and a write byte. The controller turns each request into a strobe sequence for the memory. That sequence uses an active-low primary select, an active-high secondary select, an active-low output enable and an active-low write enable. The bidirectional data bus is split into a driven value, a driver enable and a sampled input. Each read returns its byte with a one-cycle valid pulse.

Every analogue timing limit of the memory is turned into a whole number of clock cycles at elaboration time. A clock-period parameter sets the conversion, which always rounds up, and a grade parameter picks the fast or the slow set of limits. The host can also ask for low-power retention. The controller then parks the memory with the secondary select low and keeps the handshake closed. It reopens the handshake only after a recovery delay of one read-cycle time has passed since the request was withdrawn.

With the defaults (10 ns clock, fast grade), the derived counts are: write strobe W = 5, read strobe R = 6, bus release H = 2, wake-up recovery K = 6.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `mem_cs1_n`=1, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0. After reset is released, with `retain_req` low, `req_ready` is 1 and `mem_cs2` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when no access is in progress and `retain_req` is 0. Each accepted request produces exactly one memory selection, and a request held valid while `req_ready` is 0 is not lost and not repeated.
- R3: A write (`req_write`=1) selects the memory (`mem_cs1_n`=0, `mem_cs2`=1) and holds `mem_oe_n`=1 throughout. `mem_we_n` is 0 only while the memory is selected and `mem_dq_oe`=1. It stays 0 for exactly W = max(ceil(tWP), ceil(tDW), ceil(tCW), ceil(tWC)-2) cycles, which is 5 by default. `mem_dq_out` is stable and equal to `req_wdata` during that pulse.
- R4: A write commits its byte to the memory location at its address. A later read of that address returns the byte, and the last of several writes to one address wins.
- R5: A read holds `mem_oe_n`=0 with `mem_we_n`=1 and `mem_dq_oe`=0 for exactly R = max(ceil(tRC), ceil(tOE)) cycles, which is 6 by default. The byte on `mem_dq_in` at the last of those cycles is presented on `rsp_rdata` with a `rsp_valid` pulse exactly one cycle wide. Responses come in request order.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least H = ceil(tHZ) cycles, which is 2 by default. This includes a write that directly follows a read.
- R7: `mem_addr` equals the accepted address and does not change while the memory is selected.
- R8: While `retain_req` is 1 and the controller is idle, it holds `mem_cs2`=0, `mem_cs1_n`=1 and `mem_we_n`=`mem_oe_n`=1, keeps `req_ready`=0, and starts no access. After `retain_req` falls, `req_ready` returns exactly K = ceil(tRC) cycles later, which is 6 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 18 | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_rdata` holds read data |
| rsp_rdata | output | 8 | Byte returned by a read |
| retain_req | input | 1 | Request low-power retention |
| mem_addr | output | 18 | Address to the memory |
| mem_cs1_n | output | 1 | Primary select, active low |
| mem_cs2 | output | 1 | Secondary select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Driver enable for the data bus |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
A wrong state or counter value shows up at the memory pins within a single access. A strobe that is a cycle short or long changes the number of cycles in which write enable or output enable is low. A read that ends early captures the model's deliberately wrong byte, and the scoreboard catches it when the response pulse arrives. A bad turnaround shows as the data driver turning on while output enable is low, or too soon after it rises, on the first read-to-write pair. A retention fault shows as either a selection during the parked phase or a wake-up count off by a cycle, before the next request is accepted.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and elaboration-time helpers for the
// asynchronous SRAM controller. Assumes positive integer arguments.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN,
        ST_RETAIN
    } ctrl_state_t;

    // Nanoseconds to whole cycles, rounding up.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    // Larger of two integers.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_step_timer.sv
`timescale 1ns/1ps
// Module: sram_step_timer
// Down counter that sets how long each controller state lasts. Loading
// value N makes done rise N cycles later. Assumes load_val fits CNT_W.
module sram_step_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new length or count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
// Module: sram_read_capture
// Registers the byte on the memory bus when asked and raises a
// matching one-cycle valid. Assumes capture is itself a single-cycle pulse.
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    // Sample the bus and mark the response valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= bus_in;
            end
        end
    end

    // R5: a response lasts exactly one cycle.
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Module: sram_async_ctrl
// Sequences one host request at a time into select/enable strobes for an
// asynchronous SRAM, with every timing limit rounded up to whole cycles.
// Assumes the host holds request fields steady while req_valid is high and
// that mem_dq_in is already synchronous to clk at the capture edge.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 10,
    parameter bit FAST_GRADE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              retain_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Analogue limits of the selected grade, in nanoseconds.
    localparam int T_WP = FAST_GRADE ? 40 : 50;
    localparam int T_CW = FAST_GRADE ? 45 : 60;
    localparam int T_DW = FAST_GRADE ? 25 : 30;
    localparam int T_WC = FAST_GRADE ? 55 : 70;
    localparam int T_RC = FAST_GRADE ? 55 : 70;
    localparam int T_OE = FAST_GRADE ? 25 : 35;
    localparam int T_HZ = FAST_GRADE ? 20 : 25;

    // Derived cycle counts.
    localparam int WR_CYC  = max_of(max_of(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DW, CLK_NS)),
                                    max_of(ns_to_cyc(T_CW, CLK_NS), ns_to_cyc(T_WC, CLK_NS) - 2));
    localparam int RD_CYC  = max_of(ns_to_cyc(T_RC, CLK_NS), ns_to_cyc(T_OE, CLK_NS));
    localparam int HZ_CYC  = max_of(ns_to_cyc(T_HZ, CLK_NS), 1);
    localparam int RDR_CYC = max_of(ns_to_cyc(T_RC, CLK_NS), 1);
    localparam int MAX_CYC = max_of(max_of(WR_CYC, RD_CYC), max_of(HZ_CYC, RDR_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctrl_state_t       state_q, state_d;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              accept;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              selected;
    logic              capture;

    assign accept = (state_q == ST_IDLE) && !retain_req && req_valid;

    sram_step_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Next state and the length to load on each state entry.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (retain_req) begin
                    state_d  = ST_RETAIN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RDR_CYC - 1);
                end else if (req_valid) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = wr_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = wr_q ? '0 : CNT_W'(HZ_CYC - 1);
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RETAIN: begin
                if (retain_req) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RDR_CYC - 1);
                end else if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Strobe decode from the registered state.
    assign selected   = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
    assign mem_cs1_n  = !selected;
    assign mem_cs2    = (state_q != ST_RETAIN);
    assign mem_we_n   = !((state_q == ST_STROBE) && wr_q);
    assign mem_oe_n   = !((state_q == ST_STROBE) && !wr_q);
    assign mem_dq_oe  = selected && wr_q;
    assign mem_dq_out = wdata_q;
    assign mem_addr   = addr_q;
    assign req_ready  = (state_q == ST_IDLE) && !retain_req;
    assign capture    = (state_q == ST_STROBE) && !wr_q && tmr_done;

    sram_read_capture #(.DATA_W(DATA_W)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .bus_in  (mem_dq_in),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );

    // Checker counters: write-strobe width and cycles since output enable rose.
    logic [CNT_W-1:0] we_low_cnt;
    logic [CNT_W-1:0] oe_high_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= '1;
        end else begin
            we_low_cnt  <= mem_we_n ? '0 : we_low_cnt + 1'b1;
            if (!mem_oe_n) begin
                oe_high_cnt <= '0;
            end else if (oe_high_cnt != '1) begin
                oe_high_cnt <= oe_high_cnt + 1'b1;
            end
        end
    end

    // R1: reset parks every strobe inactive.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_cs1_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

    // R3: write enable only while selected, driving, with outputs off.
    assert_write_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n && mem_dq_oe));

    // R3: the write strobe lasts the full derived width.
    assert_write_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == CNT_W'(WR_CYC)));

    // R6: never drive against the memory's outputs.
    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R6: driver waits out the bus release time after a read.
    assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_high_cnt >= CNT_W'(HZ_CYC)));

    // R7: address holds while selected.
    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

    // R8: retention closes the handshake and keeps all strobes idle.
    assert_retain_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retain_req |-> !req_ready);
    assert_retain_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs2 |-> (mem_cs1_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
// Bench: scoreboard around sram_async_ctrl with a cycle-counted memory model.
module test_sram_async_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W_EXP   = 5;
    localparam int R_EXP   = 6;
    localparam int HZ_EXP  = 2;
    localparam int RDR_EXP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        retain_req = 1'b0;
    logic [17:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    sram_async_ctrl #(.CLK_NS(CLK_PERIOD), .FAST_GRADE(1'b1)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .retain_req(retain_req),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int requests = 0;
    int sel_count = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [7:0] model_mem [int];
    logic [7:0] shadow [int];
    logic [7:0] exp_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input int a);
        return model_mem.exists(a) ? model_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    // Memory model and monitor, all sampled on the falling edge.
    int oe_cnt = 0;
    int we_cnt = 0;
    int oe_hi_cnt = 100;
    logic [7:0]  wr_data_s = '0;
    logic [17:0] sel_addr = '0;
    bit sel_prev = 1'b0, wr_prev = 1'b0, rsp_prev = 1'b0, dq_oe_prev = 1'b0;

    always @(negedge clk) begin
        bit sel, wr;
        logic [7:0] exp_b;
        if (rst_n) begin
            sel = !mem_cs1_n && mem_cs2;
            // R7 address held during selection
            if (sel && sel_prev && mem_addr != sel_addr)
                check(1'b0, "R7", int'(mem_addr), int'(sel_addr));
            if (sel && !sel_prev) begin
                sel_addr = mem_addr;
                sel_count++;
            end
            // R6 contention and bus release
            if (mem_dq_oe && !mem_oe_n) check(1'b0, "R6", 1, 0);
            if (mem_oe_n) oe_hi_cnt++; else oe_hi_cnt = 0;
            if (mem_dq_oe && !dq_oe_prev)
                check(oe_hi_cnt >= HZ_EXP + 1, "R6", oe_hi_cnt, HZ_EXP + 1);
            // R3 write strobe shape
            wr = sel && !mem_we_n;
            if (!mem_we_n && !(sel && mem_oe_n && mem_dq_oe))
                check(1'b0, "R3", 0, 1);
            if (wr) begin
                if (we_cnt > 0 && mem_dq_out != wr_data_s)
                    check(1'b0, "R3", int'(mem_dq_out), int'(wr_data_s));
                wr_data_s = mem_dq_out;
                we_cnt++;
            end else if (wr_prev) begin
                check(we_cnt == W_EXP, "R3", we_cnt, W_EXP);
                model_mem[int'(sel_addr)] = wr_data_s;
                we_cnt = 0;
            end
            // R5 read model: correct byte only after R_EXP cycles of output enable
            if (sel && !mem_oe_n && mem_we_n) oe_cnt++; else oe_cnt = 0;
            mem_dq_in = (oe_cnt >= R_EXP) ? model_rd(int'(mem_addr)) : ~model_rd(int'(mem_addr));
            // R5 scoreboard pop and single-cycle pulse
            if (rsp_valid) begin
                if (rsp_prev) check(1'b0, "R5", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", int'(rsp_rdata), 0);
                end else begin
                    exp_b = exp_q.pop_front();
                    check(rsp_rdata == exp_b, "R5", int'(rsp_rdata), int'(exp_b));
                end
            end
            sel_prev   = sel;
            wr_prev    = wr;
            rsp_prev   = rsp_valid;
            dq_oe_prev = mem_dq_oe;
        end
    end

    // Driver: present one request and hold it until accepted.
    task automatic issue(input logic wr, input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        requests++;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        shadow[int'(a)] = d;
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input logic [17:0] a);
        exp_q.push_back(shadow_rd(int'(a)));
        issue(1'b0, a, 8'h00);
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(req_ready && exp_q.size() == 0) && n < 1000);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        int sel_before;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_cs1_n == 1'b1, "R1", int'(mem_cs1_n), 1);
        check(mem_we_n == 1'b1, "R1", int'(mem_we_n), 1);
        check(mem_oe_n == 1'b1, "R1", int'(mem_oe_n), 1);
        check(mem_dq_oe == 1'b0, "R1", int'(mem_dq_oe), 0);
        check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", int'(req_ready), 1);
        check(mem_cs2 == 1'b1, "R1", int'(mem_cs2), 1);

        // R3 R4 writes at edge and middle addresses
        do_write(18'h00000, 8'hA5);
        do_write(18'h3FFFF, 8'h5A);
        do_write(18'h12345, 8'h3C);
        do_write(18'h00001, 8'hFF);
        // R5 reads in a different order, plus an unwritten address
        do_read(18'h3FFFF);
        do_read(18'h00000);
        do_read(18'h00002);
        do_read(18'h12345);
        do_read(18'h00001);
        // R6 read immediately followed by a write, then read-back
        do_read(18'h00000);
        do_write(18'h00000, 8'h11);
        do_read(18'h00000);
        // R4 last write wins
        do_write(18'h2AAAA, 8'h01);
        do_write(18'h2AAAA, 8'h02);
        do_read(18'h2AAAA);
        wait_idle();
        check(model_rd(int'(18'h3FFFF)) == 8'h5A, "R4", int'(model_rd(int'(18'h3FFFF))), 8'h5A);
        check(model_rd(int'(18'h2AAAA)) == 8'h02, "R4", int'(model_rd(int'(18'h2AAAA))), 8'h02);
        check(sel_count == requests, "R2", sel_count, requests);

        // R8 retention with a pending request held valid
        @(negedge clk);
        retain_req = 1'b1;
        sel_before = sel_count;
        exp_q.push_back(shadow_rd(int'(18'h12345)));
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 18'h12345;
        repeat (6) begin
            @(negedge clk);
            check(mem_cs2 == 1'b0 && mem_cs1_n == 1'b1 && req_ready == 1'b0, "R8",
                  {int'(mem_cs2), int'(mem_cs1_n), int'(req_ready)}, 1);
        end
        retain_req = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!req_ready && k < 100);
        check(k == RDR_EXP, "R8", k, RDR_EXP);
        check(sel_count == sel_before, "R8", sel_count, sel_before);
        @(negedge clk);
        req_valid = 1'b0;
        requests++;
        wait_idle();
        // R2 held request accepted once, nothing lost or repeated
        check(sel_count == requests, "R2", sel_count, requests);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule